// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block holds the return addresses of a small processor core. It is a chain of registers of fixed depth, with no stack pointer. A call or interrupt entry pushes the current program counter. Every stored entry then moves one place deeper, and whatever sat in the deepest place drops off the end. A return pops the stack. The shallowest entry goes to the program counter and every other entry moves one place toward the top.

The storage cannot be reached from the data space. It holds addresses only, so accumulator and register saving stay in software. An occupancy counter runs from zero to the full depth and saturates at both ends. A return on an empty stack does not assert the valid indication. The core then falls through to the next sequential instruction.

Top module: `rstk_top`

## Requirements
- R1: After a synchronous active-high reset, `depth_o` is 0, `ret_addr_o` is 0 and `pop_valid_o` is 0.
- R2: A push cycle (`push_i`=1, `pop_i`=0) stores `pc_i` as the new top entry and adds one to `depth_o` below the full depth. From the next cycle, `ret_addr_o` shows that address.
- R3: Pops return the pushed addresses in reverse push order.
- R4: During a pop cycle (`pop_i`=1, `push_i`=0) with `depth_o` non-zero, `pop_valid_o` is 1 in that same cycle and `ret_addr_o` holds the top entry. On the next edge `depth_o` drops by one.
- R5: `depth_o` never exceeds 6. A push at depth 6 keeps the depth at 6 and discards the oldest address, so the next six pops return the six newest addresses and the seventh pop is invalid.
- R6: A pop at depth 0 gives `pop_valid_o`=0, leaves `depth_o` at 0 and leaves `ret_addr_o` at 0.
- R7: When `push_i` and `pop_i` are both 1, the cycle acts as a push. `pop_valid_o` stays 0 and no entry is removed.
- R8: Each pop fills the deepest place with zero, so once the stack is drained `ret_addr_o` reads 0.
- R9: A cycle with neither push nor pop leaves `depth_o` and `ret_addr_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Call or interrupt entry |
| pop_i | input | 1 | Return or interrupt return |
| pc_i | input | 12 | Program counter to save on a push |
| ret_addr_o | output | 12 | Top entry, the return address |
| pop_valid_o | output | 1 | The current pop delivers a valid address |
| depth_o | output | 3 | Number of occupied places, 0 to 6 |

## Verification
`pop_valid_o` and `ret_addr_o` are combinational in the pop cycle, so the bench drives inputs on the falling edge and samples them a few nanoseconds later, before the rising edge. A push or pop changes `depth_o` and the top entry at the next rising edge. The bench reads those values one nanosecond after that edge, in the cycle that follows the command. Overflow, the empty pop and the push-plus-pop combination are each run as separate directed sequences.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2
   } stk_op_e;

endpackage

// File: rtl/rstk_op_decode.sv
module rstk_op_decode
   import rstk_pkg::*;
#(
   parameter int CW = 3
) (
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [CW-1:0] depth_i,
   output stk_op_e       op_o,
   output logic          pop_ok_o
);

   // push wins over pop; a pop on an empty stack degrades to hold
   always_comb begin
      op_o     = OP_HOLD;
      pop_ok_o = 1'b0;
      if (push_i) begin
         op_o = OP_PUSH;
      end else if (pop_i && (depth_i != '0)) begin
         op_o     = OP_POP;
         pop_ok_o = 1'b1;
      end
   end

   always_comb begin
      AST_PUSH_WINS: assert (!(push_i && pop_ok_o)); // R7
   end

endmodule

// File: rtl/rstk_level.sv
module rstk_level
   import rstk_pkg::*;
#(
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  stk_op_e       op_i,
   input  logic [AW-1:0] from_above_i,
   input  logic [AW-1:0] from_below_i,
   output logic [AW-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_o <= '0;
      end else begin
         unique case (op_i)
            OP_PUSH: q_o <= from_above_i;
            OP_POP:  q_o <= from_below_i;
            default: q_o <= q_o;
         endcase
      end
   end

endmodule

// File: rtl/rstk_depth.sv
module rstk_depth
   import rstk_pkg::*;
#(
   parameter int DEPTH = 6,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  stk_op_e       op_i,
   output logic [CW-1:0] depth_o
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   always_ff @(posedge clk) begin
      if (rst) begin
         depth_o <= '0;
      end else begin
         unique case (op_i)
            OP_PUSH: if (depth_o != FULL) depth_o <= depth_o + 1'b1;
            OP_POP:  if (depth_o != '0)   depth_o <= depth_o - 1'b1;
            default: depth_o <= depth_o;
         endcase
      end
   end

   AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (rst)
      depth_o <= FULL); // R5
   AST_PUSH_SAT: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_PUSH && depth_o == FULL) |=> depth_o == FULL); // R5
   AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_POP) |=> depth_o == $past(depth_o) - 1'b1); // R4

endmodule

// File: rtl/rstk_top.sv
module rstk_top
   import rstk_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int AW    = 12,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic [AW-1:0] pc_i,
   output logic [AW-1:0] ret_addr_o,
   output logic          pop_valid_o,
   output logic [CW-1:0] depth_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rstk_top: DEPTH must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("rstk_top: AW must be positive");
   end

   stk_op_e       op;
   logic [AW-1:0] lvl [DEPTH];

   rstk_op_decode #(.CW(CW)) i_dec (
      .push_i   (push_i),
      .pop_i    (pop_i),
      .depth_i  (depth_o),
      .op_o     (op),
      .pop_ok_o (pop_valid_o)
   );

   rstk_depth #(.DEPTH(DEPTH)) i_depth (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op),
      .depth_o (depth_o)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
      logic [AW-1:0] above, below;
      if (g == 0) begin : g_top
         assign above = pc_i;
      end else begin : g_mid_a
         assign above = lvl[g-1];
      end
      if (g == DEPTH - 1) begin : g_bottom
         assign below = '0;
      end else begin : g_mid_b
         assign below = lvl[g+1];
      end
      rstk_level #(.AW(AW)) i_level (
         .clk          (clk),
         .rst          (rst),
         .op_i         (op),
         .from_above_i (above),
         .from_below_i (below),
         .q_o          (lvl[g])
      );
   end

   assign ret_addr_o = lvl[0];

   AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (rst)
      push_i |=> ret_addr_o == $past(pc_i)); // R2
   AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i && depth_o == '0) |=> depth_o == '0 && ret_addr_o == '0); // R6
   AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (rst)
      depth_o == '0 |-> ret_addr_o == '0); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!push_i && !pop_i) |=> $stable(depth_o) && $stable(ret_addr_o)); // R9
   AST_SIMUL_PUSH: assert property (@(posedge clk) disable iff (rst)
      (push_i && pop_i && depth_o != CW'(DEPTH)) |=> depth_o == $past(depth_o) + 1'b1); // R7

endmodule

// File: tb/test_rstk_top.sv
module test_rstk_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        push_i = 1'b0;
   logic        pop_i = 1'b0;
   logic [11:0] pc_i = '0;
   logic [11:0] ret_addr_o;
   logic        pop_valid_o;
   logic [2:0]  depth_o;

   int n_chk = 0;
   int n_fail = 0;
   logic        seen_pv;
   logic [11:0] seen_ra;

   always #10 clk = ~clk;

   rstk_top i_rstk_top (
      .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
      .ret_addr_o(ret_addr_o), .pop_valid_o(pop_valid_o), .depth_o(depth_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one command cycle: drive at falling edge, sample combinational outputs
   // before the rising edge, return 1 ns after it so state is updated
   task automatic step(input logic ph, input logic pp, input logic [11:0] pc);
      @(negedge clk);
      push_i = ph; pop_i = pp; pc_i = pc;
      #5;
      seen_pv = pop_valid_o;
      seen_ra = ret_addr_o;
      @(posedge clk);
      #1;
      push_i = 1'b0; pop_i = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step(1'b0, 1'b0, '0);
      step(1'b0, 1'b0, '0);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 depth", depth_o, 0);
      check("R1 ret_addr", ret_addr_o, 0);
      check("R1 pop_valid", pop_valid_o, 0);
   endtask

   task automatic t_lifo();
      do_reset();
      step(1'b1, 1'b0, 12'h123);
      check("R2 top after push", ret_addr_o, 12'h123);
      check("R2 depth after push", depth_o, 1);
      step(1'b1, 1'b0, 12'hABC);
      step(1'b1, 1'b0, 12'h0F0);
      check("R2 depth three", depth_o, 3);
      step(1'b0, 1'b1, '0);
      check("R4 pop_valid", seen_pv, 1);
      check("R3 first pop", seen_ra, 12'h0F0);
      check("R4 depth drop", depth_o, 2);
      step(1'b0, 1'b1, '0);
      check("R3 second pop", seen_ra, 12'hABC);
      step(1'b0, 1'b1, '0);
      check("R3 third pop", seen_ra, 12'h123);
      check("R4 third valid", seen_pv, 1);
      check("R8 drained top", ret_addr_o, 0);
   endtask

   task automatic t_overflow();
      do_reset();
      for (int i = 1; i <= 7; i++) step(1'b1, 1'b0, 12'(i * 16'h111));
      check("R5 depth saturates", depth_o, 6);
      for (int i = 7; i >= 2; i--) begin
         step(1'b0, 1'b1, '0);
         check("R5 newest kept", seen_ra, 12'(i * 16'h111));
         check("R5 pop valid", seen_pv, 1);
      end
      step(1'b0, 1'b1, '0);
      check("R5 oldest lost", seen_pv, 0);
      check("R8 zero after overflow drain", ret_addr_o, 0);
   endtask

   task automatic t_empty_pop();
      do_reset();
      step(1'b0, 1'b1, '0);
      check("R6 pop_valid", seen_pv, 0);
      check("R6 depth", depth_o, 0);
      check("R6 ret_addr", ret_addr_o, 0);
   endtask

   task automatic t_simultaneous();
      do_reset();
      step(1'b1, 1'b0, 12'h555);
      step(1'b1, 1'b1, 12'h777);
      check("R7 pop_valid", seen_pv, 0);
      check("R7 depth", depth_o, 2);
      check("R7 top", ret_addr_o, 12'h777);
   endtask

   task automatic t_idle();
      do_reset();
      step(1'b1, 1'b0, 12'h9A9);
      step(1'b0, 1'b0, 12'hFFF);
      step(1'b0, 1'b0, 12'h001);
      check("R9 depth", depth_o, 1);
      check("R9 top", ret_addr_o, 12'h9A9);
   endtask

   initial begin
      t_reset();
      t_lifo();
      t_overflow();
      t_empty_pop();
      t_simultaneous();
      t_idle();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule